// File: doc/BRIEF.md
# Channel Interrupt Flag Bank

This block keeps one pending-interrupt flag for each channel of a 16-channel DMA engine and drives those flags straight out as interrupt requests. A channel's flag is raised when the engine reports that the channel's transfer has finished and that channel's completion-interrupt enable is on. The flag stays up until software removes it.

Software removes flags through a one-byte clear command. The command can be marked as a no-op, can clear every flag at once, or can clear the single flag named by a 4-bit channel index. The command byte is the top lane of a 32-bit register word, so a full-word store can update neighbouring bytes and leave the flags alone by setting the no-op bit. The flag word can also be read back and overwritten directly over the same simple register bus, which has byte enables and a combinational read path.

Top module: `irq_flag_bank`

## Requirements
- R1: After reset every flag and every `irq_o` bit is 0, and the flag word reads back as 0.
- R2: A flag is set at the clock edge where `done_i` and `ie_i` are both 1 for that channel; with `ie_i` low for a channel, `done_i` leaves its flag unchanged.
- R3: `irq_o` always equals the flag word, and a read at byte address 0x24 returns the flags in bits 15:0 with bits 31:16 zero.
- R4: A write to byte address 0x1C with `bus_be[3]` set and `bus_wdata[31]` = 1 (no-op bit) changes no flag.
- R5: A write to 0x1C with `bus_be[3]` set, `bus_wdata[31]` = 0 and `bus_wdata[30]` = 1 (clear-all bit) clears all flags at that clock edge.
- R6: A write to 0x1C with `bus_be[3]` set and `bus_wdata[31:30]` = 00 clears only the flag whose number is `bus_wdata[27:24]`; `bus_wdata[29:28]` are reserved and have no effect.
- R7: A write to 0x1C with `bus_be[3]` clear, or a write to any other address than 0x1C or 0x24, changes no flag.
- R8: A read at byte address 0x1C (command byte at 0x1F) returns 0 whatever the flag state.
- R9: When a channel's set condition and a clear of that same channel (single or all) meet at one edge, the flag ends up set.
- R10: A write to 0x24 replaces flags 7:0 with `bus_wdata[7:0]` when `bus_be[0]` is set and flags 15:8 with `bus_wdata[15:8]` when `bus_be[1]` is set; the new value shows on `irq_o` after that edge, and a set event at the same edge still wins for its channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| done_i | input | 16 | Per-channel transfer-finished pulse |
| ie_i | input | 16 | Per-channel completion-interrupt enable |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address of a 32-bit word |
| bus_be | input | 4 | Byte lane enables for the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq_o | output | 16 | Interrupt requests, one per channel |

## Verification
The bench aims at the command decoding corners: a no-op byte carrying a live index and clear-all bit, which a design that checked clear-all first would obey and wipe flags; reserved bits set beside a valid index, which a sloppy decoder would treat as part of the index and clear the wrong channel or none; and the lane enable held low, which a design ignoring byte enables would act on. It also lines up a completion event with a clear of the same channel, where a clear-priority design would drop the interrupt, and a partial-lane direct write, which a design that ignored enables would use to corrupt the other half of the flags. A cycle-exact reference model runs beside long random traffic to catch off-by-one timing.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;

  localparam int unsigned CH_MAX     = 16;
  localparam int unsigned IDX_W      = 4;
  localparam logic [7:0]  CMD_WORD   = 8'h1C;
  localparam int unsigned CMD_LANE   = 3;
  localparam logic [7:0]  FLAG_WORD  = 8'h24;

  typedef struct packed {
    logic             fire;
    logic             all;
    logic [IDX_W-1:0] idx;
  } clr_cmd_t;

  // Bit 7 suppresses the command, bit 6 clears everything, bits 3..0 pick a channel.
  function automatic clr_cmd_t decode_cmd(input logic [7:0] b);
    clr_cmd_t c;
    c.fire = ~b[7];
    c.all  = b[6];
    c.idx  = b[IDX_W-1:0];
    return c;
  endfunction

  // Mask of flags that a decoded command removes.
  function automatic logic [CH_MAX-1:0] clear_mask(input clr_cmd_t c);
    logic [CH_MAX-1:0] m;
    m = '0;
    if (c.fire) begin
      if (c.all) m = '1;
      else       m[c.idx] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/irq_clr_decode.sv
module irq_clr_decode
  import irq_flag_pkg::*;
#(
  parameter int unsigned NCH = 16
) (
  input  logic           wr_hit,
  input  logic [7:0]     cmd_byte,
  output logic           cmd_fire,
  output logic           clr_all_ev,
  output logic           clr_one_ev,
  output logic [NCH-1:0] clr_vec
);
  clr_cmd_t          c;
  logic [CH_MAX-1:0] m;

  always_comb begin
    c          = decode_cmd(cmd_byte);
    m          = wr_hit ? clear_mask(c) : '0;
    cmd_fire   = wr_hit & c.fire;
    clr_all_ev = cmd_fire & c.all;
    clr_one_ev = cmd_fire & ~c.all;
    clr_vec    = m[NCH-1:0];
  end
endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg #(
  parameter int unsigned NCH = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] set_vec,
  input  logic [NCH-1:0] clr_vec,
  input  logic [NCH-1:0] wr_mask,
  input  logic [NCH-1:0] wr_val,
  output logic [NCH-1:0] flags
);
  logic [NCH-1:0] nxt;

  always_comb begin
    nxt = (flags & ~wr_mask) | (wr_val & wr_mask);
    nxt = nxt & ~clr_vec;
    nxt = nxt | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= nxt;
  end
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
  import irq_flag_pkg::*;
#(
  parameter int unsigned NCH = 16
) (
  input  logic [7:0]     addr,
  input  logic [NCH-1:0] flags,
  output logic [31:0]    rdata
);
  always_comb begin
    rdata = '0;
    if (addr == FLAG_WORD) rdata[NCH-1:0] = flags;
  end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irq_flag_pkg::*;
#(
  parameter int unsigned NCH = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] done_i,
  input  logic [NCH-1:0] ie_i,
  input  logic           bus_wr,
  input  logic [7:0]     bus_addr,
  input  logic [3:0]     bus_be,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  output logic [NCH-1:0] irq_o
);
  localparam int unsigned LANES = (NCH + 7) / 8;

  logic           cmd_hit;
  logic           cmd_fire;
  logic           clr_all_ev;
  logic           clr_one_ev;
  logic           pend_wr_ev;
  logic [NCH-1:0] clr_vec;
  logic [NCH-1:0] set_vec;
  logic [NCH-1:0] wr_mask;
  logic [NCH-1:0] flags;

  assign cmd_hit    = bus_wr && (bus_addr == CMD_WORD) && bus_be[CMD_LANE];
  assign pend_wr_ev = bus_wr && (bus_addr == FLAG_WORD) && |bus_be[LANES-1:0];
  assign set_vec    = done_i & ie_i;

  genvar gi;
  generate
    for (gi = 0; gi < NCH; gi++) begin : g_lane
      assign wr_mask[gi] = pend_wr_ev & bus_be[gi/8];
    end
  endgenerate

  irq_clr_decode #(.NCH(NCH)) u_dec (
    .wr_hit     (cmd_hit),
    .cmd_byte   (bus_wdata[8*CMD_LANE +: 8]),
    .cmd_fire   (cmd_fire),
    .clr_all_ev (clr_all_ev),
    .clr_one_ev (clr_one_ev),
    .clr_vec    (clr_vec)
  );

  irq_flag_reg #(.NCH(NCH)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .wr_mask (wr_mask),
    .wr_val  (bus_wdata[NCH-1:0]),
    .flags   (flags)
  );

  irq_read_mux #(.NCH(NCH)) u_rd (
    .addr  (bus_addr),
    .flags (flags),
    .rdata (bus_rdata)
  );

  assign irq_o = flags;
endmodule

// File: rtl/irq_flag_bank_chk.sv
module irq_flag_bank_chk
  import irq_flag_pkg::*;
#(
  parameter int unsigned NCH = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_wr,
  input logic [7:0]     bus_addr,
  input logic [3:0]     bus_be,
  input logic [31:0]    bus_wdata,
  input logic [31:0]    bus_rdata,
  input logic [NCH-1:0] irq_o,
  input logic [NCH-1:0] set_vec,
  input logic           clr_all_ev,
  input logic           pend_wr_ev
);
  logic noop_wr;
  assign noop_wr = bus_wr && bus_addr == CMD_WORD && bus_be[CMD_LANE] && bus_wdata[31];

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> irq_o == '0);

  assert_set_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((irq_o & $past(set_vec)) == $past(set_vec)));

  assert_flag_readback_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == FLAG_WORD) |-> (bus_rdata[NCH-1:0] == irq_o));

  assert_noop_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (noop_wr && set_vec == '0 && !pend_wr_ev) |=> $stable(irq_o));

  assert_clear_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_all_ev && set_vec == '0) |=> irq_o == '0);

  assert_cmd_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == CMD_WORD) |-> bus_rdata == '0);
endmodule

bind irq_flag_bank irq_flag_bank_chk #(.NCH(NCH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_be     (bus_be),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .irq_o      (irq_o),
  .set_vec    (set_vec),
  .clr_all_ev (clr_all_ev),
  .pend_wr_ev (pend_wr_ev)
);

// File: tb/sim_irq_flag_bank.sv
`timescale 1ns/100ps
module sim_irq_flag_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] done_i = '0;
  logic [15:0] ie_i = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] irq_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit [15:0] model = '0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  irq_flag_bank u0 (
    .clk(clk), .rst_n(rst_n), .done_i(done_i), .ie_i(ie_i),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expect_read(logic [7:0] a);
    if (a == 8'h24) return {16'h0, model};
    return 32'h0;
  endfunction

  // Model step: what the requirements say happens at one rising edge.
  task automatic model_edge();
    bit [15:0] m;
    int idx;
    m = model;
    if (bus_wr && bus_addr == 8'h24) begin
      for (int b = 0; b < 16; b++)
        if (bus_be[b / 8]) m[b] = bus_wdata[b];
    end
    if (bus_wr && bus_addr == 8'h1C && bus_be[3] && bus_wdata[31] == 1'b0) begin
      if (bus_wdata[30]) m = 16'h0;
      else begin
        idx = int'(bus_wdata[27:24]);
        m[idx] = 1'b0;
      end
    end
    for (int c = 0; c < 16; c++)
      if (done_i[c] && ie_i[c]) m[c] = 1'b1;
    model = m;
  endtask

  // Drive one cycle of stimulus, then compare outputs on the following negedge.
  task automatic step(string req, logic [15:0] d, logic [15:0] e, logic w,
                      logic [7:0] a, logic [3:0] be, logic [31:0] wd);
    done_i = d; ie_i = e; bus_wr = w; bus_addr = a; bus_be = be; bus_wdata = wd;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check({req, " irq"}, {16'h0, irq_o}, {16'h0, model});
    check({req, " rdata"}, bus_rdata, expect_read(bus_addr));
  endtask

  task automatic idle(string req);
    step(req, 16'h0, 16'h0, 1'b0, 8'h24, 4'h0, 32'h0);
  endtask

  task automatic preload(logic [15:0] v);
    step("R10 preload", 16'h0, 16'h0, 1'b1, 8'h24, 4'h3, {16'hFFFF, v});
  endtask

  initial begin
    #200000;
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset irq", {16'h0, irq_o}, 32'h0);
    rst_n = 1'b1;
    idle("R1 idle after reset");
    check("R1 readback", bus_rdata, 32'h0);

    // R2: set only with enable
    step("R2 set", 16'h0005, 16'h0001, 1'b0, 8'h24, 4'h0, 32'h0);
    check("R2 ch0 set only", {16'h0, irq_o}, 32'h0001);
    step("R2 hold", 16'h0000, 16'hFFFF, 1'b0, 8'h24, 4'h0, 32'h0);

    // R3: readback
    preload(16'hA5C3);
    check("R3 readback", bus_rdata, 32'h0000A5C3);

    // R4: no-op with clear-all and index set
    step("R4 noop", 16'h0, 16'h0, 1'b1, 8'h1C, 4'hF, 32'hC3_00_00_00);
    check("R4 unchanged", {16'h0, irq_o}, 32'hA5C3);

    // R6: clear single, reserved bits set
    step("R6 clear ch1 rsvd", 16'h0, 16'h0, 1'b1, 8'h1C, 4'h8, 32'h31_FF_FF_FF);
    check("R6 ch1 cleared", {16'h0, irq_o}, 32'hA5C1);
    step("R6 clear ch15", 16'h0, 16'h0, 1'b1, 8'h1C, 4'h8, 32'h0F_00_00_00);
    check("R6 ch15 cleared", {16'h0, irq_o}, 32'h25C1);

    // R7: lane disabled / wrong address
    step("R7 be3 low", 16'h0, 16'h0, 1'b1, 8'h1C, 4'h7, 32'h40_00_00_00);
    step("R7 other addr", 16'h0, 16'h0, 1'b1, 8'h20, 4'hF, 32'h40_00_00_00);
    check("R7 unchanged", {16'h0, irq_o}, 32'h25C1);

    // R8: command word reads zero
    step("R8 read cmd", 16'h0, 16'h0, 1'b0, 8'h1C, 4'h0, 32'h0);
    check("R8 zero", bus_rdata, 32'h0);

    // R5: clear all
    step("R5 clear all", 16'h0, 16'h0, 1'b1, 8'h1C, 4'h8, 32'h4F_00_00_00);
    check("R5 all zero", {16'h0, irq_o}, 32'h0);

    // R9: set beats clear
    preload(16'h0010);
    step("R9 single", 16'h0010, 16'h0010, 1'b1, 8'h1C, 4'h8, 32'h04_00_00_00);
    check("R9 ch4 kept", {16'h0, irq_o}, 32'h0010);
    step("R9 all", 16'h0200, 16'h0200, 1'b1, 8'h1C, 4'h8, 32'h40_00_00_00);
    check("R9 ch9 kept", {16'h0, irq_o}, 32'h0200);

    // R10: partial-lane direct write and set during write
    preload(16'h1234);
    step("R10 low lane", 16'h0, 16'h0, 1'b1, 8'h24, 4'h1, 32'h0000_FFAA);
    check("R10 low only", {16'h0, irq_o}, 32'h12AA);
    step("R10 write+set", 16'h8000, 16'h8000, 1'b1, 8'h24, 4'h2, 32'h0000_0000);
    check("R10 set wins", {16'h0, irq_o}, 32'h80AA);

    // Random traffic against the model (R2..R10)
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      case ($urandom_range(0, 3))
        0: a = 8'h1C;
        1: a = 8'h24;
        2: a = 8'h1C;
        default: a = 8'h20;
      endcase
      step("R2-random", 16'($urandom) & 16'($urandom), 16'($urandom),
           1'($urandom), a, 4'($urandom), $urandom);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule